// File: doc/BRIEF.md
# Continuous and Burst PWM Generator

This block drives a single pulse-width-modulated output. Time is measured in ticks, where one tick is `TICK_DIV` clocks (for example 10 µs of the system clock). The host programs a period and an on-time in ticks, picks continuous or burst operation with a mode code, and chooses which level counts as "on" with a polarity bit. Writing 1 to the enable bit starts the waveform. Writing 0 stops it.

After the start, the output first spends one full period at the off level. It then repeats periods made of an on interval followed by an off interval. In continuous mode this goes on until the host clears the enable bit. In burst mode the block counts finished periods. After the programmed number of periods it clears the enable bit itself, so a later write of 1 starts a fresh burst. A new period or on-time is taken in only at a period boundary, so a pulse is never cut short.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset the enable bit reads 0. While the generator is not running, the output holds the off level: low when polarity is 0 and high when polarity is 1.
- R2: Mode code 32 selects continuous operation. After the host writes 1, the output stays at the off level for one lead-in period of P ticks. It then repeats periods of W ticks on followed by P−W ticks off, where one tick is `TICK_DIV` clocks.
- R3: With polarity 0 the on level is high. With polarity 1 the on level is low and every level of the waveform is inverted.
- R4: Mode code 33 selects burst operation. After the lead-in, exactly N on pulses are produced (a count of 0 acts as 1). At the end of the last period the enable bit clears itself and the output returns to the off level.
- R5: After a burst has cleared the enable bit, a new write of 1 starts a complete new burst, lead-in included.
- R6: A host write of 0 to the enable bit clears it at the next clock edge, and the output is at the off level from that edge on.
- R7: Period and width values written while the generator runs are taken in only at the next period boundary.
- R8: While the width in use is greater than or equal to the period in use, the output stays at the off level.
- R9: A write of 1 while the enable bit is already 1 does not restart the waveform.
- R10: With a mode code other than 32 or 33, the enable bit follows the host writes, but the output stays at the off level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeCode | input | 8 | Mode code, sampled when the generator starts (32 continuous, 33 burst) |
| enWrStb | input | 1 | One-cycle host write strobe for the enable bit |
| enWrData | input | 1 | Value written to the enable bit |
| periodTicks | input | CNT_W | Period in ticks |
| widthTicks | input | CNT_W | On-time in ticks |
| cycleCount | input | CNT_W | Number of periods in a burst, sampled at start |
| polarity | input | 1 | 0: on level high; 1: on level low |
| pwmOut | output | 1 | PWM waveform |
| enableBit | output | 1 | Current enable bit, including the self-clear |

## Verification
Continuous runs are made with both polarities. They show whether the lead-in, the on/off split and the inversion are placed on the right clock. Bursts of three, two and zero pulses check the count, the self-clear and the re-arm, and show an off-by-one in the cycle counter. A run where period and width are changed in the middle of the lead-in tells an immediate load apart from a load at the boundary. Runs with the width equal to the period, a redundant enable write, and a non-PWM mode code check the cases that must leave the output or the phase untouched.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam logic [7:0] MODE_PWM_CONT  = 8'd32;
  localparam logic [7:0] MODE_PWM_BURST = 8'd33;

  // strobes from control to datapath
  typedef struct packed {
    logic start;  // generator (re)starts this cycle
    logic tick;   // one tick elapses at this edge
    logic run;    // generator running
  } pwmStrb_t;

  function automatic logic isPwmMode(input logic [7:0] code);
    return (code == MODE_PWM_CONT) || (code == MODE_PWM_BURST);
  endfunction

endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       modeCode,
  input  logic             enWrStb,
  input  logic             enWrData,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             periodWrap,
  input  logic             leadActive,
  output pwmStrb_t         strb,
  output logic             enableBit,
  output logic             burstArmed
);

  localparam int DIV_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W:0] ONE_X = 1;

  logic             enableQ;
  logic             pwmQ;
  logic             burstQ;
  logic [CNT_W-1:0] cycTarget;
  logic [CNT_W-1:0] cycDone;
  logic             startNow;
  logic             runNow;
  logic             tickNow;
  logic             periodDone;
  logic             burstFinish;

  assign startNow = enWrStb && enWrData && !enableQ;
  assign runNow   = enableQ && pwmQ;

  // tick divider: collapses to a wire when one clock is one tick
  generate
    if (TICK_DIV > 1) begin : g_div
      logic [DIV_W-1:0] divCnt;
      logic             divLast;
      assign divLast = (divCnt == DIV_W'(TICK_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rstN || !runNow) divCnt <= '0;
        else if (divLast)     divCnt <= '0;
        else                  divCnt <= divCnt + 1'b1;
      end
      assign tickNow = runNow && divLast;
    end else begin : g_nodiv
      assign tickNow = runNow;
    end
  endgenerate

  // a period that carried a pulse slot has just ended
  assign periodDone  = tickNow && periodWrap && !leadActive;
  assign burstFinish = burstQ && periodDone &&
                       (({1'b0, cycDone} + ONE_X) >= {1'b0, cycTarget});

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
    end else if (burstFinish) begin
      enableQ <= 1'b0;
    end else if (enWrStb) begin
      enableQ <= enWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmQ      <= 1'b0;
      burstQ    <= 1'b0;
      cycTarget <= '0;
    end else if (startNow) begin
      pwmQ      <= isPwmMode(modeCode);
      burstQ    <= (modeCode == MODE_PWM_BURST);
      cycTarget <= cycleCount;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || startNow) cycDone <= '0;
    else if (periodDone)   cycDone <= cycDone + 1'b1;
  end

  assign strb.start = startNow;
  assign strb.tick  = tickNow;
  assign strb.run   = runNow;
  assign enableBit  = enableQ;
  assign burstArmed = burstQ;

endmodule

// File: rtl/pwm_gen_datapath.sv
module pwm_gen_datapath
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  pwmStrb_t         strb,
  input  logic [CNT_W-1:0] periodTicks,
  input  logic [CNT_W-1:0] widthTicks,
  input  logic             polarity,
  output logic             pwmOut,
  output logic             periodWrap,
  output logic             leadActive,
  output logic [CNT_W-1:0] curPeriod,
  output logic [CNT_W-1:0] curWidth
);

  localparam logic [CNT_W-1:0] ONE   = 1;
  localparam logic [CNT_W:0]   ONE_X = 1;

  logic [CNT_W-1:0] pos;
  logic [CNT_W-1:0] pLat;
  logic [CNT_W-1:0] wLat;
  logic             lead;
  logic             onNow;

  // a zero period behaves as a single tick
  assign periodWrap = ({1'b0, pos} + ONE_X) >= {1'b0, pLat};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos  <= '0;
      pLat <= '0;
      wLat <= '0;
      lead <= 1'b0;
    end else if (strb.start) begin
      pos  <= '0;
      pLat <= periodTicks;
      wLat <= widthTicks;
      lead <= 1'b1;
    end else if (strb.tick) begin
      if (periodWrap) begin
        pos  <= '0;
        lead <= 1'b0;
        pLat <= periodTicks;
        wLat <= widthTicks;
      end else begin
        pos <= pos + ONE;
      end
    end
  end

  assign onNow      = strb.run && !lead && (pos < wLat) && (wLat < pLat);
  assign pwmOut     = onNow ^ polarity;
  assign leadActive = lead;
  assign curPeriod  = pLat;
  assign curWidth   = wLat;

endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W    = 32,
  parameter int TICK_DIV = 1000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       modeCode,
  input  logic             enWrStb,
  input  logic             enWrData,
  input  logic [CNT_W-1:0] periodTicks,
  input  logic [CNT_W-1:0] widthTicks,
  input  logic [CNT_W-1:0] cycleCount,
  input  logic             polarity,
  output logic             pwmOut,
  output logic             enableBit
);

  pwmStrb_t         strb;
  logic             periodWrap;
  logic             leadActive;
  logic             burstArmed;
  logic [CNT_W-1:0] curPeriod;
  logic [CNT_W-1:0] curWidth;

  pwm_gen_ctrl #(.CNT_W(CNT_W), .TICK_DIV(TICK_DIV)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeCode   (modeCode),
    .enWrStb    (enWrStb),
    .enWrData   (enWrData),
    .cycleCount (cycleCount),
    .periodWrap (periodWrap),
    .leadActive (leadActive),
    .strb       (strb),
    .enableBit  (enableBit),
    .burstArmed (burstArmed)
  );

  pwm_gen_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .periodTicks (periodTicks),
    .widthTicks  (widthTicks),
    .polarity    (polarity),
    .pwmOut      (pwmOut),
    .periodWrap  (periodWrap),
    .leadActive  (leadActive),
    .curPeriod   (curPeriod),
    .curWidth    (curWidth)
  );

endmodule

// File: rtl/pwm_burst_gen_chk.sv
module pwm_burst_gen_chk
  import pwm_gen_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             enWrStb,
  input logic             enWrData,
  input logic             polarity,
  input logic             pwmOut,
  input logic             enableBit,
  input pwmStrb_t         strb,
  input logic             leadActive,
  input logic             burstArmed,
  input logic [CNT_W-1:0] curPeriod,
  input logic [CNT_W-1:0] curWidth
);

  assert_off_when_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !enableBit |-> (pwmOut == polarity));

  assert_lead_in_off_R2: assert property (@(posedge clk) disable iff (!rstN)
    leadActive |-> (pwmOut == polarity));

  assert_selfclear_only_burst_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(enableBit) && !$past(enWrStb)) |-> $past(burstArmed));

  assert_stop_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (enWrStb && !enWrData) |=> (!enableBit && (pwmOut == polarity)));

  assert_wide_is_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (curWidth >= curPeriod) |-> (pwmOut == polarity));

  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enableBit && enWrStb && enWrData) |-> !strb.start);

endmodule

bind pwm_burst_gen pwm_burst_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .enWrStb    (enWrStb),
  .enWrData   (enWrData),
  .polarity   (polarity),
  .pwmOut     (pwmOut),
  .enableBit  (enableBit),
  .strb       (strb),
  .leadActive (leadActive),
  .burstArmed (burstArmed),
  .curPeriod  (curPeriod),
  .curWidth   (curWidth)
);

// File: tb/sim_pwm_burst_gen.sv
`timescale 1ns/1ps
module sim_pwm_burst_gen;

  localparam int CNT_W = 32;
  localparam int DIV   = 3;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [7:0]       modeCode = 8'd32;
  logic             enWrStb = 1'b0;
  logic             enWrData = 1'b0;
  logic [CNT_W-1:0] periodTicks = '0;
  logic [CNT_W-1:0] widthTicks = '0;
  logic [CNT_W-1:0] cycleCount = '0;
  logic             polarity = 1'b0;
  logic             pwmOut;
  logic             enableBit;

  always #2 clk = ~clk;  // 250 MHz

  pwm_burst_gen #(.CNT_W(CNT_W), .TICK_DIV(DIV)) u0 (
    .clk(clk), .rstN(rstN), .modeCode(modeCode), .enWrStb(enWrStb),
    .enWrData(enWrData), .periodTicks(periodTicks), .widthTicks(widthTicks),
    .cycleCount(cycleCount), .polarity(polarity), .pwmOut(pwmOut),
    .enableBit(enableBit)
  );

  int    nCompared = 0;
  int    nBad = 0;
  string curReq = "R1";
  bit    done = 1'b0;

  // behavioural reference: clocks elapsed inside the current period
  bit    mEn, mRun, mBurst, mLead, fin;
  longint mClk, mLen, mP, mW, mN, mDone;

  function automatic longint lenOf(input longint p);
    return ((p == 0) ? 1 : p) * DIV;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mEn = 0; mRun = 0; mBurst = 0; mLead = 0;
      mClk = 0; mLen = 1; mP = 0; mW = 0; mN = 1; mDone = 0;
    end else begin
      fin = 0;
      if (mRun) begin
        if (mClk == mLen - 1) begin
          if (!mLead) begin
            mDone++;
            if (mBurst && mDone >= mN) fin = 1;
          end
          mLead = 0;
          mP = longint'(periodTicks);
          mW = longint'(widthTicks);
          mLen = lenOf(mP);
          mClk = 0;
        end else begin
          mClk++;
        end
      end
      if (fin) begin
        mEn = 0; mRun = 0;
      end else if (enWrStb) begin
        if (enWrData && !mEn) begin
          mEn = 1;
          mRun = (modeCode == 8'd32) || (modeCode == 8'd33);
          mBurst = (modeCode == 8'd33);
          mN = (cycleCount == 0) ? 1 : longint'(cycleCount);
          mDone = 0;
          mP = longint'(periodTicks);
          mW = longint'(widthTicks);
          mLen = lenOf(mP);
          mClk = 0;
          mLead = 1;
        end else if (!enWrData) begin
          mEn = 0; mRun = 0;
        end
      end
    end
  end

  // on-pulse counter, in terms of the on level
  int  onEdges = 0;
  bit  prevOn = 0;
  logic expOut;

  always @(negedge clk) begin
    if (!done) begin
      expOut = (mRun && !mLead && (mClk < mW * DIV) && (mW < mP)) ^ polarity;
      nCompared++;
      if (pwmOut !== expOut || enableBit !== mEn) begin
        nBad++;
        $display("FAIL %s t=%0t out=%b/en=%b expected out=%b/en=%b",
                 curReq, $time, pwmOut, enableBit, expOut, mEn);
      end
      if ((pwmOut ^ polarity) && !prevOn) onEdges++;
      prevOn = pwmOut ^ polarity;
    end
  end

  task automatic check(input string req, input longint act, input longint exp);
    nCompared++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic writeEn(input bit v);
    enWrStb = 1'b1; enWrData = v;
    step(1);
    enWrStb = 1'b0; enWrData = 1'b0;
  endtask

  task automatic setup(input logic [7:0] m, input int p, input int w,
                       input int n, input bit pol);
    modeCode = m; periodTicks = p; widthTicks = w; cycleCount = n; polarity = pol;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nBad);
    $finish;
  endtask

  initial begin
    #(200000 * 4);
    nBad++;
    $display("FAIL watchdog expired in %s", curReq);
    finishRun();
  end

  initial begin
    step(5);
    curReq = "R1";
    check("R1 enable after reset", enableBit, 0);
    check("R1 output after reset", pwmOut, 0);
    rstN = 1'b1;
    step(2);
    polarity = 1'b1;
    step(2);
    check("R1 idle off level pol1", pwmOut, 1);
    polarity = 1'b0;
    step(2);

    // continuous, polarity 0
    curReq = "R2";
    setup(8'd32, 5, 2, 0, 0);
    writeEn(1);
    onEdges = 0;
    step(75);
    check("R2 pulses in four periods", onEdges, 4);
    curReq = "R6";
    writeEn(0);
    check("R6 enable cleared", enableBit, 0);
    check("R6 output off", pwmOut, 0);
    step(5);

    // continuous, polarity 1
    curReq = "R3";
    setup(8'd32, 5, 2, 0, 1);
    writeEn(1);
    step(50);
    writeEn(0);
    check("R3 off level high", pwmOut, 1);
    step(5);

    // burst of three
    curReq = "R4";
    setup(8'd33, 4, 1, 3, 0);
    onEdges = 0;
    writeEn(1);
    step(100);
    check("R4 burst pulse count", onEdges, 3);
    check("R4 enable self-cleared", enableBit, 0);

    // re-arm with two pulses
    curReq = "R5";
    cycleCount = 2;
    onEdges = 0;
    writeEn(1);
    step(80);
    check("R5 re-armed burst count", onEdges, 2);
    check("R5 enable cleared again", enableBit, 0);

    // zero count acts as one, polarity 1
    curReq = "R4";
    setup(8'd33, 3, 2, 0, 1);
    onEdges = 0;
    writeEn(1);
    step(60);
    check("R4 zero count gives one pulse", onEdges, 1);

    // mid-run reprogramming
    curReq = "R7";
    setup(8'd32, 6, 3, 0, 0);
    writeEn(1);
    step(8);
    periodTicks = 4; widthTicks = 1;
    step(90);
    writeEn(0);
    step(4);

    // width not below period
    curReq = "R8";
    setup(8'd32, 3, 3, 0, 0);
    onEdges = 0;
    writeEn(1);
    step(40);
    widthTicks = 7;
    step(30);
    check("R8 no pulses", onEdges, 0);
    writeEn(0);
    step(4);

    // redundant enable write
    curReq = "R9";
    setup(8'd32, 5, 2, 0, 0);
    writeEn(1);
    step(20);
    writeEn(1);
    step(40);
    writeEn(0);
    step(4);

    // non-PWM mode code
    curReq = "R10";
    setup(8'd5, 4, 2, 0, 0);
    onEdges = 0;
    writeEn(1);
    step(30);
    check("R10 enable follows write", enableBit, 1);
    check("R10 no pulses", onEdges, 0);
    writeEn(0);
    check("R10 enable written 0", enableBit, 0);
    step(4);

    finishRun();
  end

endmodule